// File: doc/BRIEF.md
# Status Flag Register Unit

This unit holds an 8-bit processor status byte and works out its arithmetic condition flags from one 8-bit addition or subtraction. Each cycle it takes two operands and a two-bit operation code. Its combinational output is the arithmetic result. On the next rising clock edge the flags taken from that result are stored into the status byte, one flag at a time, as the per-flag write enables allow.

The two upper bits are general-purpose state: an interrupt-enable bit and a single bit of copy storage. No arithmetic touches them. They change only through the whole-byte load port or through a single-bit set/clear port. The carry-in for the carry-using operations comes from the carry bit already stored in the unit, so chains of multi-byte arithmetic need no outside help.

Top module: `sreg_flag_unit`

## Requirements
- R1: While rst_ni is low the status byte is 0x00, and it stays 0x00 after reset is released until something writes it.
- R2: result_o is the low 8 bits of a+b (op 0), a+b+C (op 1), a-b (op 2) or a-b-C (op 3), where C is the stored carry in status bit 0.
- R3: Status bit 0 (carry) is written as the unsigned carry out of an addition, or as 1 when a subtraction needs a borrow.
- R4: Status bit 1 (zero) is written as 1 exactly when the 8-bit result is 0x00.
- R5: Status bit 2 (negative) is written as bit 7 of the result.
- R6: Status bit 3 (overflow) is written as 1 when the true two's complement result lies outside -128..127.
- R7: Status bit 4 (sign) is written as the exclusive-or of the negative and overflow values, which gives the true sign of the signed result.
- R8: Status bit 5 (half carry) is written as the carry out of bit 3 of an addition, or as the borrow into bit 3 of a subtraction.
- R9: flag_we_i[k] enables the update of status bit k for k = 0..5. A flag whose enable is low keeps its stored value.
- R10: When load_en_i is high, the status byte takes load_data_i on the next edge. This overrides every flag update and bit operation in the same cycle.
- R11: When bit_en_i is high and load_en_i is low, status bit bit_idx_i takes bit_val_i. This overrides an arithmetic update of that bit. Bits 6 and 7 change only through this port or the load port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_a_i | input | 8 | First operand |
| op_b_i | input | 8 | Second operand |
| op_sel_i | input | 2 | 0 add, 1 add with carry, 2 subtract, 3 subtract with carry |
| flag_we_i | input | 6 | Per-flag update enables for status bits 0..5 |
| load_en_i | input | 1 | Load the whole status byte |
| load_data_i | input | 8 | Byte to load |
| bit_en_i | input | 1 | Single-bit write enable |
| bit_idx_i | input | 3 | Status bit to write |
| bit_val_i | input | 1 | Value for that bit |
| result_o | output | 8 | Arithmetic result (combinational) |
| status_o | output | 8 | Stored status byte |

## Verification
The clocked properties sample result_o one cycle after the update they describe. They therefore assume the operands and op_sel_i stay steady from the sampling edge onward, and that bit_idx_i is valid whenever bit_en_i is high. The driver changes every input just after a rising edge and holds it for the whole cycle. It parks all enables at zero during reset so the first post-reset comparisons start from a known byte.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int unsigned SR_W      = 8;
  localparam int unsigned ARITH_N   = 6;
  localparam int unsigned FLAG_C    = 0;
  localparam int unsigned FLAG_Z    = 1;
  localparam int unsigned FLAG_N    = 2;
  localparam int unsigned FLAG_V    = 3;
  localparam int unsigned FLAG_S    = 4;
  localparam int unsigned FLAG_H    = 5;
  localparam int unsigned FLAG_T    = 6;
  localparam int unsigned FLAG_I    = 7;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_ADC = 2'd1,
    OP_SUB = 2'd2,
    OP_SBC = 2'd3
  } arith_op_e;

  // packed MSB..LSB matches status bits 5..0
  typedef struct packed {
    logic h;
    logic s;
    logic v;
    logic n;
    logic z;
    logic c;
  } arith_flags_t;
endpackage

// File: rtl/sreg_arith.sv
module sreg_arith
  import sreg_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  arith_op_e     op_i,
  input  logic          carry_i,
  output logic [DW-1:0] result_o,
  output arith_flags_t  flags_o
);
  localparam int unsigned HW = DW / 2;

  logic          is_sub;
  logic          cin;
  logic          cin_eff;
  logic [DW-1:0] b_eff;
  logic [DW:0]   sum_w;
  logic [HW:0]   low_w;
  logic          a_msb, b_msb, r_msb;

  always_comb begin
    is_sub  = op_i[1];
    cin     = op_i[0] & carry_i;
    // subtract as a + ~b + ~cin
    b_eff   = is_sub ? ~b_i : b_i;
    cin_eff = is_sub ? ~cin : cin;
    sum_w   = {1'b0, a_i} + {1'b0, b_eff} + {{DW{1'b0}}, cin_eff};
    low_w   = {1'b0, a_i[HW-1:0]} + {1'b0, b_eff[HW-1:0]} + {{HW{1'b0}}, cin_eff};
    result_o = sum_w[DW-1:0];

    a_msb = a_i[DW-1];
    b_msb = b_i[DW-1];
    r_msb = sum_w[DW-1];

    flags_o.c = is_sub ? ~sum_w[DW] : sum_w[DW];
    flags_o.h = is_sub ? ~low_w[HW] : low_w[HW];
    flags_o.z = (sum_w[DW-1:0] == '0);
    flags_o.n = r_msb;
    if (is_sub) flags_o.v = (a_msb & ~b_msb & ~r_msb) | (~a_msb & b_msb & r_msb);
    else        flags_o.v = (a_msb &  b_msb & ~r_msb) | (~a_msb & ~b_msb & r_msb);
    flags_o.s = flags_o.n ^ flags_o.v;
  end
endmodule

// File: rtl/sreg_merge.sv
module sreg_merge
  import sreg_pkg::*;
#(
  parameter int unsigned W  = SR_W,
  parameter int unsigned AN = ARITH_N,
  localparam int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  cur_i,
  input  logic [AN-1:0] arith_i,
  input  logic [AN-1:0] we_i,
  input  logic          load_en_i,
  input  logic [W-1:0]  load_data_i,
  input  logic          bit_en_i,
  input  logic [IW-1:0] bit_idx_i,
  input  logic          bit_val_i,
  output logic [W-1:0]  next_o
);
  logic [W-1:0] upd;

  for (genvar k = 0; k < W; k++) begin : g_bit
    if (k < AN) begin : g_arith
      assign upd[k] = we_i[k] ? arith_i[k] : cur_i[k];
    end else begin : g_hold
      assign upd[k] = cur_i[k];
    end
  end

  // priority: load > single bit > flag update
  always_comb begin
    next_o = upd;
    if (bit_en_i) next_o[bit_idx_i] = bit_val_i;
    if (load_en_i) next_o = load_data_i;
  end
endmodule

// File: rtl/sreg_flag_unit.sv
module sreg_flag_unit
  import sreg_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [DW-1:0]        op_a_i,
  input  logic [DW-1:0]        op_b_i,
  input  logic [1:0]           op_sel_i,
  input  logic [ARITH_N-1:0]   flag_we_i,
  input  logic                 load_en_i,
  input  logic [SR_W-1:0]      load_data_i,
  input  logic                 bit_en_i,
  input  logic [2:0]           bit_idx_i,
  input  logic                 bit_val_i,
  output logic [DW-1:0]        result_o,
  output logic [SR_W-1:0]      status_o
);
  arith_flags_t    flags;
  logic [SR_W-1:0] status_q, status_d;

  sreg_arith #(.DW(DW)) u_arith (
    .a_i      (op_a_i),
    .b_i      (op_b_i),
    .op_i     (arith_op_e'(op_sel_i)),
    .carry_i  (status_q[FLAG_C]),
    .result_o (result_o),
    .flags_o  (flags)
  );

  sreg_merge #(.W(SR_W), .AN(ARITH_N)) u_merge (
    .cur_i       (status_q),
    .arith_i     (flags),
    .we_i        (flag_we_i),
    .load_en_i   (load_en_i),
    .load_data_i (load_data_i),
    .bit_en_i    (bit_en_i),
    .bit_idx_i   (bit_idx_i),
    .bit_val_i   (bit_val_i),
    .next_o      (status_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= status_d;
  end

  assign status_o = status_q;

  logic quiet_arith;
  assign quiet_arith = !load_en_i && !bit_en_i;

  assert_load_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_en_i |=> status_o == $past(load_data_i));

  assert_hold_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet_arith && flag_we_i == '0) |=> $stable(status_o));

  assert_sign_xor_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet_arith && flag_we_i[FLAG_S] && flag_we_i[FLAG_N] && flag_we_i[FLAG_V])
    |=> status_o[FLAG_S] == (status_o[FLAG_N] ^ status_o[FLAG_V]));

  assert_zero_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet_arith && flag_we_i[FLAG_Z]) |=> status_o[FLAG_Z] == ($past(result_o) == '0));

  assert_neg_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet_arith && flag_we_i[FLAG_N]) |=> status_o[FLAG_N] == $past(result_o[DW-1]));

  assert_upper_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_en_i && !(bit_en_i && bit_idx_i >= 3'd6)) |=> $stable(status_o[7:6]));

  assert_bit_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && !load_en_i) |=> status_o[$past(bit_idx_i)] == $past(bit_val_i));
endmodule

// File: tb/sreg_flag_unit_test.sv
`timescale 1ns/1ps
module sreg_flag_unit_test;
  logic       clk = 0;
  logic       rst_ni = 0;
  logic [7:0] op_a = 0, op_b = 0;
  logic [1:0] op_sel = 0;
  logic [5:0] flag_we = 0;
  logic       load_en = 0;
  logic [7:0] load_data = 0;
  logic       bit_en = 0;
  logic [2:0] bit_idx = 0;
  logic       bit_val = 0;
  logic [7:0] result, status;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sreg_flag_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .op_a_i(op_a), .op_b_i(op_b), .op_sel_i(op_sel),
    .flag_we_i(flag_we), .load_en_i(load_en), .load_data_i(load_data),
    .bit_en_i(bit_en), .bit_idx_i(bit_idx), .bit_val_i(bit_val),
    .result_o(result), .status_o(status)
  );

  typedef struct {
    logic [7:0] res;
    logic [7:0] sr;
    string      tag;
  } item_t;

  item_t q[$];
  logic [7:0] model_sr = 0;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // returns {result, h,s,v,n,z,c}
  function automatic logic [13:0] ref_alu(input logic [1:0] op, input logic [7:0] a,
                                          input logic [7:0] b, input logic c);
    int ua = a, ub = b, ci = op[0] ? int'(c) : 0;
    int sa = (a > 127) ? int'(a) - 256 : int'(a);
    int sb = (b > 127) ? int'(b) - 256 : int'(b);
    int full, sres;
    logic cf, hf, vf, nf, zf, sf;
    logic [7:0] r;
    if (!op[1]) begin
      full = ua + ub + ci;  cf = full > 255;
      hf = ((ua % 16) + (ub % 16) + ci) > 15;
      sres = sa + sb + ci;
    end else begin
      full = ua - ub - ci;  cf = full < 0;
      hf = ((ua % 16) - (ub % 16) - ci) < 0;
      sres = sa - sb - ci;
    end
    r  = full[7:0];
    vf = (sres > 127) || (sres < -128);
    nf = r[7];
    zf = (r == 8'h00);
    sf = nf ^ vf;
    return {r, hf, sf, vf, nf, zf, cf};
  endfunction

  task automatic drive(input string tag, input logic [1:0] op, input logic [7:0] a,
                       input logic [7:0] b, input logic [5:0] we,
                       input logic ld = 0, input logic [7:0] ldd = 0,
                       input logic be = 0, input logic [2:0] bi = 0, input logic bv = 0);
    logic [13:0] ref_v;
    logic [7:0]  nxt;
    item_t it;
    @(posedge clk); #1;
    op_sel = op; op_a = a; op_b = b; flag_we = we;
    load_en = ld; load_data = ldd; bit_en = be; bit_idx = bi; bit_val = bv;
    ref_v = ref_alu(op, a, b, model_sr[0]);
    nxt = model_sr;
    for (int k = 0; k < 6; k++) if (we[k]) nxt[k] = ref_v[k];
    if (be) nxt[bi] = bv;
    if (ld) nxt = ldd;
    it.res = ref_v[13:6]; it.sr = nxt; it.tag = tag;
    q.push_back(it);
    model_sr = nxt;
  endtask

  // monitor: result checked mid-cycle, status checked one edge later
  item_t stash;
  bit    have_stash = 0;
  initial forever begin
    @(negedge clk);
    if (have_stash) check({stash.tag, " status"}, status, stash.sr);
    if (q.size() > 0) begin
      stash = q.pop_front();
      check({stash.tag, " result"}, result, stash.res);
      have_stash = 1;
    end else have_stash = 0;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 in reset", status, 8'h00);
    rst_ni = 1;
    @(negedge clk);
    check("R1 after release", status, 8'h00);

    drive("R2 R8 add nibble carry", 2'd0, 8'h0F, 8'h01, 6'h3F);
    drive("R3 R4 add wrap", 2'd0, 8'hFF, 8'h01, 6'h3F);
    drive("R6 R5 add signed overflow", 2'd0, 8'h7F, 8'h01, 6'h3F);
    drive("R3 R8 sub borrow", 2'd2, 8'h00, 8'h01, 6'h3F);
    drive("R6 R7 sub signed overflow", 2'd2, 8'h80, 8'h01, 6'h3F);
    drive("R11 set carry bit", 2'd0, 8'h00, 8'h00, 6'h00, 0, 0, 1, 3'd0, 1);
    drive("R2 adc uses carry", 2'd1, 8'h10, 8'h20, 6'h3F);
    drive("R3 sub borrow again", 2'd2, 8'h00, 8'h01, 6'h3F);
    drive("R2 sbc uses carry", 2'd3, 8'h05, 8'h02, 6'h3F);
    drive("R2 adc carry clear", 2'd1, 8'h40, 8'h02, 6'h3F);
    drive("R4 sub equal", 2'd2, 8'h5A, 8'h5A, 6'h3F);
    drive("R9 zero only enabled", 2'd0, 8'hC0, 8'hC0, 6'h02);
    drive("R9 no enables", 2'd2, 8'h00, 8'h7F, 6'h00);
    drive("R10 load over update", 2'd0, 8'hFF, 8'hFF, 6'h3F, 1, 8'hA5);
    drive("R11 set interrupt bit", 2'd0, 8'h01, 8'h01, 6'h3F, 0, 0, 1, 3'd7, 1);
    drive("R11 clear carry over update", 2'd0, 8'hF0, 8'h20, 6'h3F, 0, 0, 1, 3'd0, 0);
    drive("R11 upper bits hold", 2'd3, 8'h80, 8'h7F, 6'h3F);
    drive("R7 sign negative no overflow", 2'd2, 8'h10, 8'h20, 6'h3F);
    drive("R10 load zero", 2'd1, 8'h01, 8'h01, 6'h3F, 1, 8'h00, 1, 3'd6, 1);
    drive("R8 sbc half borrow", 2'd3, 8'h10, 8'h01, 6'h20);
    drive("idle", 2'd0, 8'h00, 8'h00, 6'h00);
    drive("idle", 2'd0, 8'h00, 8'h00, 6'h00);
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule